// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Load Port

This block is the target side of a byte-parallel configuration interface. An external loader supplies a configuration clock, an active-low select, an active-low write strobe and an 8-bit bus. After reset the block first clears its internal configuration buffer and holds a shared open-drain status line low. It then releases the line and waits until the line is actually seen high, because another agent on the wired-AND node may still be holding it. Only after that does it start taking bytes, one per rising edge. Each byte goes into the buffer and into a running CRC-16.

A load has a fixed length set by a parameter. Its last two bytes are a CRC trailer, so a good load raises a done output and locks out further writes. After done, the same bus can be turned around to read the stored bytes back in order. A bad trailer pulls the status line low for good. Releasing the write strobe partway through a load aborts it. In both failure cases only a reset starts a new load.

The bus numbers its bits in reverse: pin 0 carries the most significant bit of each byte.

Top module: `cfg_par_port`

## Requirements
- R1: Pin `data_i[0]` carries bit 7 (the MSB) of the byte and pin 7 carries bit 0. Pins 0 to 3 hold the high nibble. Readback drives `data_o` with the same mapping.
- R2: `stat_oe_o` is 1 from reset through the first `LOAD_LEN` rising edges after reset is released while the buffer is cleared, then goes to 0.
- R3: After clearing, no byte is accepted until `stat_i` has been sampled high on a rising edge. Write strobes before that are not counted.
- R4: In the load phase a byte is accepted on a rising edge exactly when `cs_ni` and `rdwr_ni` are both 0. Either signal may fall first, and cycles with `cs_ni` high are not counted.
- R5: The last two of the `LOAD_LEN` bytes are the CRC-16 of all earlier bytes, high byte first. The CRC uses polynomial 0x1021 and initial value 0xFFFF, and each byte enters it MSB first. On a match, `done_o` is 1 from the cycle after the last byte edge until reset, and later writes are ignored.
- R6: On a trailer mismatch, `stat_oe_o` is 1 from the cycle after the last byte edge until reset, and `done_o` stays 0.
- R7: If `rdwr_ni` is sampled high after 1 to `LOAD_LEN-1` bytes have been accepted, the load aborts. After that `done_o` stays 0, `stat_oe_o` stays 0, and further writes are ignored until reset.
- R8: After done, a rising edge with `cs_ni`=0 and `rdwr_ni`=1 makes `data_oe_o`=1 in the next cycle, with `data_o` showing stored byte k. The index k starts at 0, steps by one per readback edge and wraps after `LOAD_LEN-1`.
- R9: `data_oe_o` is 0 in every cycle not produced by such a readback edge, including readback attempts before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rdwr_ni | input | 1 | 0 = write, 1 = readback |
| data_i | input | 8 | Bus input, pin 0 = MSB |
| data_o | output | 8 | Bus output for readback, pin 0 = MSB |
| data_oe_o | output | 1 | Bus output enable |
| stat_i | input | 1 | Observed level of the open-drain status node |
| stat_oe_o | output | 1 | 1 pulls the status node low |
| done_o | output | 1 | Load completed with a good CRC |

## Verification
The assertions assume that `cs_ni`, `rdwr_ni`, `data_i` and `stat_i` change only away from the rising edge. They also assume that `stat_i` follows the wired-AND of `stat_oe_o` and the external hold. The bench meets both conditions: it drives every input on the falling edge, and it builds `stat_i` from its own hold signal combined with the block's pull-down. Within those limits the stimulus covers the cases where the write strobe and select fall in either order, select gaps in the middle of a load, write and readback attempts outside their phases, good and corrupted trailers, and an abort partway through a load.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;
  typedef enum logic [2:0] {
    ST_CLR, ST_WAIT, ST_LOAD, ST_DONE, ST_ERR, ST_ABORT
  } cfg_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/cfg_bus_map.sv
module cfg_bus_map #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] y_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign y_o[i] = a_i[WIDTH-1-i];
  end
endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import cfg_par_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_SEED;
    else if (init_i) crc_o <= CRC_SEED;
    else if (en_i)   crc_o <= crc16_step(crc_o, byte_i);
  end

  assert_crc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/cfg_buf.sv
module cfg_buf #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfg_par_port.sv
module cfg_par_port #(
  parameter int unsigned LOAD_LEN = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rdwr_ni,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  input  logic       stat_i,
  output logic       stat_oe_o,
  output logic       done_o
);
  import cfg_par_pkg::*;

  localparam int unsigned AW = $clog2(LOAD_LEN);
  localparam int unsigned CW = AW + 1;

  cfg_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] clr_q, rd_q;
  logic          swept_q, oe_q;
  logic [7:0]    hi_q, dout_q, in_byte, rd_byte;
  logic [15:0]   crc;
  logic          wr_fire, rb_fire, sweep, last, match;

  cfg_bus_map #(.WIDTH(8)) u_map_in  (.a_i(data_i), .y_o(in_byte));
  cfg_bus_map #(.WIDTH(8)) u_map_out (.a_i(dout_q), .y_o(data_o));

  assign wr_fire = (state_q == ST_LOAD) && !cs_ni && !rdwr_ni;
  assign rb_fire = (state_q == ST_DONE) && !cs_ni && rdwr_ni;
  assign sweep   = (state_q == ST_CLR || state_q == ST_ERR || state_q == ST_ABORT) && !swept_q;
  assign last    = cnt_q == CW'(LOAD_LEN - 1);
  assign match   = {hi_q, in_byte} == crc;

  cfg_crc16 u_crc (
    .clk_i, .rst_ni,
    .init_i (state_q == ST_WAIT),
    .en_i   (wr_fire && (cnt_q < CW'(LOAD_LEN - 2))),
    .byte_i (in_byte),
    .crc_o  (crc)
  );

  cfg_buf #(.DEPTH(LOAD_LEN)) u_buf (
    .clk_i,
    .we_i    (wr_fire || sweep),
    .waddr_i (sweep ? clr_q : cnt_q[AW-1:0]),
    .wdata_i (sweep ? 8'h00 : in_byte),
    .raddr_i (rd_q),
    .rdata_o (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLR;
      cnt_q   <= '0;
      clr_q   <= '0;
      swept_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      if (sweep) begin
        clr_q <= clr_q + 1'b1;
        if (clr_q == AW'(LOAD_LEN - 1)) swept_q <= 1'b1;
      end
      if (wr_fire) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(LOAD_LEN - 2)) hi_q <= in_byte;
      end
      unique case (state_q)
        ST_CLR:  if (clr_q == AW'(LOAD_LEN - 1)) state_q <= ST_WAIT;
        ST_WAIT: if (stat_i) begin
          state_q <= ST_LOAD;
          swept_q <= 1'b0;
          clr_q   <= '0;
        end
        ST_LOAD: begin
          if (wr_fire && last) state_q <= match ? ST_DONE : ST_ERR;
          else if (rdwr_ni && cnt_q != '0) state_q <= ST_ABORT;
        end
        default: ;
      endcase
    end
  end

  // readback path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= rb_fire;
      if (rb_fire) begin
        dout_q <= rd_byte;
        rd_q   <= (rd_q == AW'(LOAD_LEN - 1)) ? '0 : rd_q + 1'b1;
      end
    end
  end

  assign data_oe_o = oe_q;
  assign stat_oe_o = (state_q == ST_CLR) || (state_q == ST_ERR);
  assign done_o    = (state_q == ST_DONE);

  assert_rb_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !cs_ni && rdwr_ni) |=> data_oe_o);
  assert_oe_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == ST_DONE && !cs_ni && rdwr_ni) |=> !data_oe_o);
  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR) |=> (stat_oe_o && !done_o));
  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && rdwr_ni && cnt_q != '0) |=> (state_q == ST_ABORT));
  assert_wait_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !stat_i) |=> (state_q == ST_WAIT && cnt_q == '0));
  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && !cs_ni && !rdwr_ni) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_clear_pull_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLR) |-> (stat_oe_o && !data_oe_o));
endmodule

// File: tb/cfg_par_port_test.sv
module cfg_par_port_test;
  localparam int LEN = 64;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rdwr_n = 1, hold_n = 1;
  logic [7:0] pins = '0;
  logic [7:0] data_o;
  logic data_oe, stat_oe, done, stat_in;
  int n_chk = 0, n_fail = 0;
  bit run_cmp = 0;

  always #5 clk = ~clk;
  assign stat_in = hold_n & ~stat_oe;

  cfg_par_port #(.LOAD_LEN(LEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rdwr_ni(rdwr_n),
    .data_i(pins), .data_o(data_o), .data_oe_o(data_oe),
    .stat_i(stat_in), .stat_oe_o(stat_oe), .done_o(done)
  );

  function automatic logic [7:0] rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [15:0] crc_of(input logic [7:0] q[$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c ^= {q[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 clear, 1 wait, 2 load, 3 done, 4 error, 5 abort
  int m_phase, m_clr, m_rd;
  logic [7:0] m_q[$];
  logic m_oe;
  logic [7:0] m_pins;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_clr <= 0; m_rd <= 0; m_oe <= 0; m_q.delete();
    end else begin
      m_oe <= 0;
      case (m_phase)
        0: begin m_clr <= m_clr + 1; if (m_clr == LEN - 1) m_phase <= 1; end
        1: if (stat_in) m_phase <= 2;
        2: if (!cs_n && !rdwr_n) begin
             m_q.push_back(rev(pins));
             if (m_q.size() == LEN) begin
               if (crc_of(m_q, LEN - 2) == {m_q[LEN-2], m_q[LEN-1]}) m_phase <= 3;
               else m_phase <= 4;
             end
           end else if (rdwr_n && m_q.size() > 0) m_phase <= 5;
        3: if (!cs_n && rdwr_n) begin
             m_oe <= 1; m_pins <= rev(m_q[m_rd]); m_rd <= (m_rd + 1) % LEN;
           end
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (run_cmp && rst_n) begin
    string sreq;
    sreq = (m_phase == 0) ? "R2" : (m_phase == 4) ? "R6" : (m_phase == 5) ? "R7" : "R3";
    check(stat_oe == (m_phase == 0 || m_phase == 4), sreq, stat_oe, (m_phase == 0 || m_phase == 4));
    check(done == (m_phase == 3), "R5", done, m_phase == 3);
    check(data_oe == m_oe, "R9", data_oe, m_oe);
    if (m_oe) check(data_o == m_pins, "R8 R1", data_o, m_pins);
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cs_n = 1; rdwr_n = 1;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    pins = rev(b); cs_n = 0; rdwr_n = 0;
  endtask

  task automatic gap();
    @(negedge clk);
    cs_n = 1;
  endtask

  task automatic build(output logic [7:0] s[$], input int seed, input bit bad);
    logic [15:0] c;
    s.delete();
    for (int i = 0; i < LEN - 2; i++) s.push_back(8'((i * 37 + seed) ^ (i << 3)));
    c = crc_of(s, LEN - 2);
    s.push_back(c[15:8]);
    s.push_back(bad ? ~c[7:0] : c[7:0]);
  endtask

  task automatic load(input logic [7:0] s[$]);
    for (int i = 0; i < s.size(); i++) begin
      put(s[i]);
      if (i % 7 == 3) gap();
    end
    gap();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s[$];
    run_cmp = 1;
    // scenario 1: external hold, write attempts while waiting, good load, readback
    hold_n = 0;
    do_reset();
    @(negedge clk);
    check(stat_oe == 1, "R2 reset pull", stat_oe, 1);
    repeat (LEN + 2) @(negedge clk);
    check(stat_oe == 0, "R2 release", stat_oe, 0);
    put(8'hAA); put(8'h55); gap();              // ignored: node held low
    check(done == 0, "R3 no accept while held", done, 0);
    hold_n = 1;
    @(negedge clk); rdwr_n = 0;                   // write strobe falls before select
    @(negedge clk);
    build(s, 5, 0);
    load(s);
    check(done == 1, "R5 good trailer", done, 1);
    check(stat_oe == 0, "R5 line released", stat_oe, 0);
    put(8'h12); gap();
    check(done == 1, "R5 writes after done ignored", done, 1);
    @(negedge clk); rdwr_n = 1;
    for (int i = 0; i < LEN + 3; i++) begin
      @(negedge clk); cs_n = (i % 5 == 2);
    end
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    check(data_oe == 0, "R9 idle after readback", data_oe, 0);

    // scenario 2: select first (readback attempt before done), then good load
    do_reset();
    repeat (LEN + 2) @(negedge clk);
    @(negedge clk); cs_n = 0; rdwr_n = 1;
    @(negedge clk);
    check(data_oe == 0, "R9 readback before done", data_oe, 0);
    build(s, 91, 0);
    load(s);
    check(done == 1, "R4 select first then strobe", done, 1);

    // scenario 3: corrupted trailer
    do_reset();
    repeat (LEN + 2) @(negedge clk);
    build(s, 17, 1);
    load(s);
    check(stat_oe == 1, "R6 error pull", stat_oe, 1);
    check(done == 0, "R6 no done", done, 0);
    repeat (4) @(negedge clk);
    check(stat_oe == 1, "R6 sticky", stat_oe, 1);

    // scenario 4: abort mid-load, then a full good stream is ignored
    do_reset();
    repeat (LEN + 2) @(negedge clk);
    build(s, 3, 0);
    for (int i = 0; i < 5; i++) put(s[i]);
    @(negedge clk); cs_n = 1; rdwr_n = 1;
    @(negedge clk);
    load(s);
    check(done == 0, "R7 abort blocks done", done, 0);
    check(stat_oe == 0, "R7 line stays released", stat_oe, 0);

    run_cmp = 0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule